// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits on the bus side of an I2C target. It watches already-synchronised SCL and SDA samples, finds START and repeated START conditions, and shifts in the address byte or bytes that follow. It then decides whether the device answers. When it answers, it asks the pad logic to pull SDA low for the acknowledge clock.

The own address is a 10-bit value, and a mode input selects whether 7 of its bits or all 10 take part in the compare. The general call address is answered only when it is enabled. An optional refusal rule declines any address match while received data is still waiting in the receive FIFO, and raises an error flag in place of the match flag.

An own-address match and a general call match raise separate flags, which stay up until the next START. The read/write bit of the accepted address appears on a direction output a fixed number of cycles after the flag rises.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, and on every cycle while `en` is 0, `sda_pull`, `own_hit`, `gc_hit`, `dnr_err` and `rd_dir` are 0, and bus activity while `en` is 0 has no effect.
- R2: In 7-bit mode (`ten_bit`=0), a first byte whose upper seven bits equal `own_addr[6:0]` is acknowledged and sets `own_hit`. Acknowledge means that `sda_pull` rises on the SCL falling edge after the eighth bit and falls on the SCL falling edge after the ninth.
- R3: A first byte that matches neither the own address nor an enabled general call is not acknowledged, and no flag is set.
- R4: The byte 0x00 (seven zero address bits, write) is acknowledged and sets `gc_hit` only while `gc_en` is 1; with `gc_en`=0 it is ignored. The byte 0x01 (general call with read) is never acknowledged.
- R5: In 10-bit mode, a first byte of 11110 followed by `own_addr[9:8]` and a 0 R/W bit is acknowledged without setting a flag. A second byte equal to `own_addr[7:0]` is then acknowledged and sets `own_hit`; any other second byte is not acknowledged.
- R6: After a completed 10-bit write match, a repeated START followed by the 10-bit header with R/W=1 is acknowledged, sets `own_hit` and gives `rd_dir`=1. After a STOP, that read header is no longer acknowledged.
- R7: When `dnr_en`=1 and `rx_empty`=0, an address that would otherwise be matched (own or general call) is not acknowledged. `dnr_err` is set instead of the match flag. With `rx_empty`=1 the match proceeds normally.
- R8: `rd_dir` takes the R/W bit of an accepted address exactly DIR_LAG (default 3) clock cycles after `own_hit` or `gc_hit` rises. A general call gives 0.
- R9: A START or repeated START clears all three flags and begins a new address phase. A STOP returns the block to idle, and the flags hold until the next START.
- R10: At most one of `own_hit`, `gc_hit` and `dnr_err` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Matcher enable; 0 holds the block idle |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| ten_bit | input | 1 | 1 selects a 10-bit own address, 0 a 7-bit one |
| own_addr | input | 10 | Own address (7-bit mode uses bits 6:0) |
| gc_en | input | 1 | Answer the general call address |
| dnr_en | input | 1 | Refuse matches while the receive FIFO holds data |
| rx_empty | input | 1 | Receive FIFO is empty |
| sda_pull | output | 1 | Request to drive SDA low (acknowledge) |
| own_hit | output | 1 | Own address matched |
| gc_hit | output | 1 | General call matched |
| dnr_err | output | 1 | Match refused by the pending-data rule |
| rd_dir | output | 1 | Delayed R/W bit of the accepted address (1 = read) |

## Verification
On every cycle, the assertions check the following properties:
- the acknowledge request only rises right after an SCL falling edge;
- the three flags are mutually exclusive;
- a refusal never coexists with a pull request;
- a general call flag only appears with the gate open;
- a START always clears the flags;
- the block is quiet while disabled;
- the direction output changes only at the fixed lag after a flag.

Whether a given byte is acknowledged at all is shown only by the bench's bus scenarios. These cover the 7-bit vectors, the 10-bit write and read sequences, the loss of the read header after a STOP, and the refusal rule.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_BITS = 8;
    localparam int ADDR_BITS = 10;
    localparam logic [4:0] TEN_HDR = 5'b11110;
    localparam logic [6:0] GC_ADDR = 7'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DECIDE,
        ST_ACK,
        ST_HOLD
    } am_state_t;

    typedef struct packed {
        logic ack;   // drive acknowledge
        logic hit;   // own address accepted
        logic gcm;   // general call accepted
        logic hdr;   // 10-bit write header accepted, second byte follows
        logic dnr;   // match refused, receive data pending
        logic rw;    // R/W bit of the byte
    } am_verdict_t;

    function automatic am_verdict_t am_judge(
        input logic [BYTE_BITS-1:0] b,
        input logic                 ten,
        input logic [ADDR_BITS-1:0] own,
        input logic                 gc_on,
        input logic                 dnr_on,
        input logic                 rx_emp,
        input logic                 second,
        input logic                 armed
    );
        am_verdict_t v;
        v    = '0;
        v.rw = b[0];
        if (second) begin
            v.hit = (b == own[7:0]);
            v.rw  = 1'b0;
        end else if (!ten && b[7:1] == own[6:0]) begin
            v.hit = 1'b1;
        end else if (ten && b[7:3] == TEN_HDR && b[2:1] == own[9:8]) begin
            if (!b[0]) v.hdr = 1'b1;
            else       v.hit = armed;
        end else if (b[7:1] == GC_ADDR && !b[0] && gc_on) begin
            v.gcm = 1'b1;
        end
        if ((v.hit || v.gcm) && dnr_on && !rx_emp) begin
            v.dnr = 1'b1;
            v.hit = 1'b0;
            v.gcm = 1'b0;
        end
        v.ack = v.hit || v.gcm || v.hdr;
        return v;
    endfunction

endpackage

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = scl_i && !scl_q;
    assign scl_fall = !scl_i && scl_q;
    assign start_ev = scl_i && scl_q && sda_q && !sda_i;
    assign stop_ev  = scl_i && scl_q && !sda_q && sda_i;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift import i2c_am_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 take,
    input  logic                 sda_i,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 full
);
    localparam int CW = $clog2(BYTE_BITS + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(BYTE_BITS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            byte_o <= '0;
        end else if (take && cnt != FULL_CNT) begin
            byte_o <= {byte_o[BYTE_BITS-2:0], sda_i};
            cnt    <= cnt + 1'b1;
        end
    end

    assign full = (cnt == FULL_CNT);
endmodule

// File: rtl/i2c_am_dirlag.sv
module i2c_am_dirlag #(
    parameter int DIR_LAG = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic rw_in,
    output logic rd_dir
);
    localparam int CW = $clog2(DIR_LAG + 1);
    localparam logic [CW-1:0] LAG_CNT = CW'(DIR_LAG);

    logic [CW-1:0] cnt;
    logic          hold;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            hold   <= 1'b0;
            rd_dir <= 1'b0;
        end else if (load) begin
            cnt  <= LAG_CNT;
            hold <= rw_in;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) rd_dir <= hold;
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match import i2c_am_pkg::*; #(
    parameter int DIR_LAG = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 ten_bit,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 gc_en,
    input  logic                 dnr_en,
    input  logic                 rx_empty,
    output logic                 sda_pull,
    output logic                 own_hit,
    output logic                 gc_hit,
    output logic                 dnr_err,
    output logic                 rd_dir
);
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic sh_clr, sh_take, sh_full, decide, dir_load;
    logic [BYTE_BITS-1:0] sh_byte;
    logic second, armed, next_second;
    am_state_t   state;
    am_verdict_t verdict;

    i2c_am_cond u_cond (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign sh_take = en && (state == ST_SHIFT) && scl_rise;
    assign sh_clr  = !en || start_ev || ((state == ST_ACK) && scl_fall);

    i2c_am_shift u_shift (
        .clk(clk), .rst(rst), .clr(sh_clr), .take(sh_take),
        .sda_i(sda_i), .byte_o(sh_byte), .full(sh_full)
    );

    assign verdict  = am_judge(sh_byte, ten_bit, own_addr, gc_en, dnr_en,
                               rx_empty, second, armed);
    assign decide   = en && (state == ST_DECIDE) && scl_fall && !start_ev && !stop_ev;
    assign dir_load = decide && (verdict.hit || verdict.gcm);

    i2c_am_dirlag #(.DIR_LAG(DIR_LAG)) u_dir (
        .clk(clk), .rst(rst), .clr(!en), .load(dir_load),
        .rw_in(verdict.rw), .rd_dir(rd_dir)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state       <= ST_IDLE;
            second      <= 1'b0;
            armed       <= 1'b0;
            next_second <= 1'b0;
            sda_pull    <= 1'b0;
            own_hit     <= 1'b0;
            gc_hit      <= 1'b0;
            dnr_err     <= 1'b0;
        end else if (start_ev) begin
            state    <= ST_SHIFT;
            second   <= 1'b0;
            sda_pull <= 1'b0;
            own_hit  <= 1'b0;
            gc_hit   <= 1'b0;
            dnr_err  <= 1'b0;
        end else if (stop_ev) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
            armed    <= 1'b0;
        end else begin
            case (state)
                ST_SHIFT:  if (sh_full) state <= ST_DECIDE;
                ST_DECIDE: if (decide) begin
                    if (verdict.ack) begin
                        state       <= ST_ACK;
                        sda_pull    <= 1'b1;
                        own_hit     <= verdict.hit;
                        gc_hit      <= verdict.gcm;
                        next_second <= verdict.hdr;
                        if (second && verdict.hit) armed <= 1'b1;
                    end else begin
                        state   <= ST_HOLD;
                        armed   <= 1'b0;
                        dnr_err <= verdict.dnr;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    sda_pull <= 1'b0;
                    if (next_second) begin
                        state  <= ST_SHIFT;
                        second <= 1'b1;
                    end else begin
                        state <= ST_HOLD;
                    end
                    next_second <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk #(
    parameter int DIR_LAG = 3
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic scl_i,
    input logic sda_i,
    input logic gc_en,
    input logic sda_pull,
    input logic own_hit,
    input logic gc_hit,
    input logic dnr_err,
    input logic rd_dir
);
    localparam int CW = $clog2(DIR_LAG + 2);
    localparam logic [CW-1:0] SAT = CW'(DIR_LAG + 1);

    logic          hit_q;
    logic [CW-1:0] since_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q     <= 1'b0;
            since_hit <= SAT;
        end else begin
            hit_q <= own_hit || gc_hit;
            if ((own_hit || gc_hit) && !hit_q) since_hit <= CW'(1);
            else if (since_hit != SAT)        since_hit <= since_hit + 1'b1;
        end
    end

    // R2: acknowledge begins right after an SCL falling edge
    p_pull_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> (!$past(scl_i) && $past(scl_i, 2)));

    // R1: disabled block stays silent
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sda_pull && !own_hit && !gc_hit && !dnr_err && !rd_dir));

    // R10: flags are mutually exclusive
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({own_hit, gc_hit, dnr_err}));

    // R7: a refusal never acknowledges
    p_no_pull_dnr_r7: assert property (@(posedge clk) disable iff (rst)
        dnr_err |-> !sda_pull);

    // R4: general call flag needs the gate
    p_gc_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(gc_hit) |-> $past(gc_en));

    // R9: START clears flags
    p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (en && scl_i && $past(scl_i) && $past(sda_i) && !sda_i)
        |=> (!own_hit && !gc_hit && !dnr_err));

    // R8: direction only moves at the fixed lag
    p_dir_lag_r8: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(rd_dir)) |-> (since_hit == CW'(DIR_LAG)));
endmodule

bind i2c_addr_match i2c_am_chk #(.DIR_LAG(DIR_LAG)) chk_i (
    .clk(clk), .rst(rst), .en(en), .scl_i(scl_i), .sda_i(sda_i),
    .gc_en(gc_en), .sda_pull(sda_pull), .own_hit(own_hit),
    .gc_hit(gc_hit), .dnr_err(dnr_err), .rd_dir(rd_dir)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb_top;
    localparam int H = 4;
    localparam int LAG = 3;

    typedef struct packed {
        logic       ten;
        logic [9:0] own;
        logic       gc;
        logic       dnr;
        logic       rxe;
        logic [7:0] b;
        logic       ack;
        logic       oh;
        logic       gh;
        logic       de;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 10'h02A, 1'b0, 1'b0, 1'b1, 8'h54, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 write
        '{1'b0, 10'h02A, 1'b0, 1'b0, 1'b1, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 read
        '{1'b0, 10'h02A, 1'b0, 1'b0, 1'b1, 8'h56, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
        '{1'b0, 10'h02A, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 gc on
        '{1'b0, 10'h02A, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 gc off
        '{1'b0, 10'h02A, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 gc read
        '{1'b0, 10'h02A, 1'b0, 1'b1, 1'b0, 8'h54, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 refuse
        '{1'b0, 10'h02A, 1'b0, 1'b1, 1'b1, 8'h54, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 empty
        '{1'b0, 10'h02A, 1'b0, 1'b0, 1'b0, 8'h54, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 rule off
        '{1'b0, 10'h07F, 1'b0, 1'b0, 1'b1, 8'hFE, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 all ones
        '{1'b1, 10'h2A5, 1'b0, 1'b0, 1'b1, 8'h54, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 ten mode
        '{1'b1, 10'h2A5, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}  // R7 gc refused
    };

    logic clk = 1'b0, rst = 1'b1, en = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic ten_bit = 1'b0, gc_en = 1'b0, dnr_en = 1'b0, rx_empty = 1'b1;
    logic [9:0] own_addr = 10'h02A;
    logic sda_pull, own_hit, gc_hit, dnr_err, rd_dir;

    int errors = 0, checks = 0;
    bit done = 0;
    int cyc = 0, t_hit = 0, t_dir = 0;
    logic hit_d = 1'b0, dir_d = 1'b0;

    always #2.5 clk = ~clk;

    i2c_addr_match #(.DIR_LAG(LAG)) dut_i (
        .clk(clk), .rst(rst), .en(en), .scl_i(scl), .sda_i(sda),
        .ten_bit(ten_bit), .own_addr(own_addr), .gc_en(gc_en),
        .dnr_en(dnr_en), .rx_empty(rx_empty), .sda_pull(sda_pull),
        .own_hit(own_hit), .gc_hit(gc_hit), .dnr_err(dnr_err), .rd_dir(rd_dir)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        hit_d <= own_hit || gc_hit;
        dir_d <= rd_dir;
        if ((own_hit || gc_hit) && !hit_d) t_hit <= cyc;
        if (rd_dir != dir_d) t_dir <= cyc;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda = 1'b1; scl = 1'b1; wait_n(H);
        sda = 1'b0; wait_n(H);
        scl = 1'b0; wait_n(H);
    endtask

    task automatic i2c_restart();
        sda = 1'b1; wait_n(H);
        scl = 1'b1; wait_n(H);
        sda = 1'b0; wait_n(H);
        scl = 1'b0; wait_n(H);
    endtask

    task automatic i2c_stop();
        sda = 1'b0; wait_n(H);
        scl = 1'b1; wait_n(H);
        sda = 1'b1; wait_n(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            wait_n(1);
            sda = b[i]; wait_n(H);
            scl = 1'b1; wait_n(H);
            scl = 1'b0;
        end
        wait_n(1);
        sda = 1'b1; wait_n(H);
        scl = 1'b1; wait_n(2);
        ack = sda_pull;
        wait_n(2);
        scl = 1'b0; wait_n(2);
        rel = !sda_pull;
        wait_n(H - 2);
    endtask

    logic a, r;

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R1: reset state
        chk(!sda_pull && !own_hit && !gc_hit && !dnr_err && !rd_dir, "R1 reset outputs",
            {sda_pull, own_hit, gc_hit, dnr_err, rd_dir}, 0);
        // R1: disabled, a matching address is ignored
        i2c_start();
        send_byte(8'h54, a, r);
        chk(!a && !own_hit, "R1 disabled ignores bus", {a, own_hit}, 0);
        i2c_stop();
        en = 1'b1;
        wait_n(2);

        for (int k = 0; k < NV; k++) begin
            ten_bit = VEC[k].ten; own_addr = VEC[k].own; gc_en = VEC[k].gc;
            dnr_en = VEC[k].dnr; rx_empty = VEC[k].rxe;
            i2c_start();
            send_byte(VEC[k].b, a, r);
            chk(a == VEC[k].ack, $sformatf("R2/R3/R4/R7 vec %0d ack", k), a, VEC[k].ack);
            chk({own_hit, gc_hit, dnr_err} == {VEC[k].oh, VEC[k].gh, VEC[k].de},
                $sformatf("R2/R4/R7/R10 vec %0d flags", k),
                {own_hit, gc_hit, dnr_err}, {VEC[k].oh, VEC[k].gh, VEC[k].de});
            if (VEC[k].ack) chk(r, $sformatf("R2 vec %0d release after ninth", k), !r, 0);
            i2c_stop();
            wait_n(2);
        end

        // R9: restart clears flags, new phase starts
        ten_bit = 1'b0; own_addr = 10'h02A; gc_en = 1'b0; dnr_en = 1'b0; rx_empty = 1'b1;
        i2c_start();
        send_byte(8'h54, a, r);
        i2c_restart();
        chk(!own_hit, "R9 restart clears own_hit", own_hit, 0);
        send_byte(8'h56, a, r);
        chk(!a && !own_hit, "R9 new phase mismatch", {a, own_hit}, 0);
        i2c_stop();
        chk(!sda_pull, "R9 stop idle", sda_pull, 0);

        // R8: direction lag on a 7-bit read
        i2c_start();
        send_byte(8'h54, a, r);
        i2c_restart();
        send_byte(8'h55, a, r);
        wait_n(6);
        chk(rd_dir == 1'b1, "R8 read direction", rd_dir, 1);
        chk(t_dir - t_hit == LAG, "R8 lag cycles", t_dir - t_hit, LAG);
        i2c_stop();

        // R5: 10-bit write match
        ten_bit = 1'b1; own_addr = 10'h2A5;
        i2c_start();
        send_byte(8'hF4, a, r);
        chk(a && !own_hit, "R5 header acked without flag", {a, own_hit}, 2);
        send_byte(8'hA5, a, r);
        chk(a && own_hit, "R5 second byte match", {a, own_hit}, 3);
        wait_n(6);
        chk(rd_dir == 1'b0, "R8 write direction", rd_dir, 0);
        // R6: repeated START, read header
        i2c_restart();
        send_byte(8'hF5, a, r);
        chk(a && own_hit, "R6 10-bit read acked", {a, own_hit}, 3);
        wait_n(6);
        chk(rd_dir == 1'b1, "R6 read direction", rd_dir, 1);
        i2c_stop();
        // R6: after STOP, read header alone is refused
        i2c_start();
        send_byte(8'hF5, a, r);
        chk(!a && !own_hit, "R6 read header after stop", {a, own_hit}, 0);
        i2c_stop();
        // R5: wrong second byte
        i2c_start();
        send_byte(8'hF4, a, r);
        send_byte(8'hA4, a, r);
        chk(!a && !own_hit, "R5 second byte mismatch", {a, own_hit}, 0);
        i2c_stop();
        // R5: wrong upper bits in header
        i2c_start();
        send_byte(8'hF2, a, r);
        chk(!a, "R5 header upper bits mismatch", a, 0);
        i2c_stop();

        // R1: dropping enable clears state
        i2c_start();
        send_byte(8'hF4, a, r);
        send_byte(8'hA5, a, r);
        en = 1'b0;
        wait_n(2);
        chk(!own_hit && !rd_dir, "R1 disable clears", {own_hit, rd_dir}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule